// File: doc/BRIEF.md
# PLL clock-source control and lock monitor

This block sits next to a phase-locked loop and decides which of three clocks drives the system: a crystal oscillator, the PLL output or a real-time-clock oscillator. Software reaches it through a small register bus with two 8-bit registers. The block turns the PLL on and off. It qualifies the PLL's raw lock indication before it trusts it, raises interrupts when qualified lock is gained or lost, and prevents any switch to a clock that is not ready.

Lock counts as qualified once the synchronized raw lock has stayed high for a programmed number of consecutive windows. The window is either a short one (one reference cycle) or a long one (twenty reference cycles). The PLL can become the system clock only while it is enabled, qualified as locked and reported valid. If it is the selected clock and any of these conditions goes away, the selection drops back to the crystal. The lock rule cannot change while the PLL runs. The glitch-free clock switch itself sits outside this block and is driven by the select output.

Top module: `pllc_top`

## Requirements
- R1: After reset, clk_sel is 00, pll_en is 0, irq is 0, and both registers read 0x00.
- R2: Register 0 bits [1:0] form the source field: 00 crystal, 01 PLL, 10 RTC oscillator. A write of 00 takes effect only while xtal_ok is 1, and a write of 10 only while rtc_ok is 1. Otherwise the previous source stays. The field drives clk_sel from the next cycle on.
- R3: A write of source code 11 leaves the source unchanged, and clk_sel never shows 11.
- R4: A write of source code 01 takes effect only when pll_en is 1, lock is qualified and pll_clk_ok is 1. Otherwise the previous source stays.
- R5: While the source is 01, if pll_en, the qualified lock or pll_clk_ok goes low, the source field and clk_sel change to 00 on the next cycle.
- R6: Register 0 bits [3:2] form the lock-criteria field. Writes to it take effect only while pll_en is 0.
- R7: Register 1 bit 5 reads the qualified lock. The raw lock passes through two flip-flops. After that, lock qualifies after N consecutive windows that are all high. The criteria codes are: 00 gives 8 windows of 1 cycle, 01 gives 16 of 1, 10 gives 8 of 20, and 11 gives 16 of 20. If raw lock rises just before edge 1, with the PLL enabled and the synchronizer holding 0, bit 5 reads 1 after edge N*L+2 and reads 0 after edge N*L+1.
- R8: Any synchronized low sample, and pll_en at 0, clears the qualified lock and restarts the count from zero.
- R9: Register 1 bit 3 is a sticky flag that sets one cycle after qualified lock rises. Register 1 bit 4 is a sticky flag that sets one cycle after qualified lock falls, including a fall caused by disabling the PLL.
- R10: Register 1 bit 0 is pll_en, bit 1 enables the lock flag and bit 2 enables the unlock flag. irq is high exactly when an enabled flag is set.
- R11: Writing 1 to bit 3 or bit 4 of register 1 clears that flag. Writing 0 to either bit leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 config, 1 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| lock_raw | input | 1 | Asynchronous raw lock from the PLL |
| xtal_ok | input | 1 | Crystal clock valid |
| pll_clk_ok | input | 1 | PLL clock valid |
| rtc_ok | input | 1 | RTC oscillator clock valid |
| clk_sel | output | 2 | Active clock-source code for the clock mux |
| pll_en | output | 1 | PLL enable |
| irq | output | 1 | Interrupt request |

## Verification
The source field is driven with a table of write codes combined with the crystal and RTC valid levels. This separates accepted codes, codes refused because their clock is invalid, the reserved code and PLL requests made while unlocked. Lock is qualified under the short-window rule with 8 and 16 windows and under the long-window rule with 8 windows. Each is sampled one edge before and one edge at the expected time, which tells the window length apart from the window count and shows the synchronizer latency. A single-cycle dropout in the middle of counting shows that the count restarts rather than pauses. Losing lock and disabling the PLL while it is selected both check the fallback to the crystal and the unlock flag.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_PLL  = 2'b01,
        SRC_RTC  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    // register 0 layout
    localparam int CFG_SRC_LO  = 0;
    localparam int CFG_CRIT_LO = 2;
    // register 1 layout
    localparam int CTL_EN      = 0;
    localparam int CTL_LOCK_IE = 1;
    localparam int CTL_UNLK_IE = 2;
    localparam int CTL_LOCK_FL = 3;
    localparam int CTL_UNLK_FL = 4;
    localparam int CTL_LOCKED  = 5;

    typedef struct packed {
        logic unlk_flag;
        logic lock_flag;
        logic unlk_ie;
        logic lock_ie;
        logic en;
    } ctl_t;

    // cycles in one window: bit 1 of the criteria picks the long window
    function automatic int win_cycles(input logic [1:0] crit, input int short_w, input int long_w);
        return crit[1] ? long_w : short_w;
    endfunction

    // consecutive windows required: bit 0 picks the larger count
    function automatic int win_needed(input logic [1:0] crit, input int few_w, input int many_w);
        return crit[0] ? many_w : few_w;
    endfunction

endpackage

// File: rtl/pllc_lock_qual.sv
module pllc_lock_qual
    import pllc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_WIN   = 1,
    parameter int LONG_WIN    = 20,
    parameter int FEW_WIN     = 8,
    parameter int MANY_WIN    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] crit,
    input  logic       lock_raw,
    output logic       lock_sync,
    output logic       locked
);
    localparam int SUB_W = $clog2(LONG_WIN + 1);
    localparam int WIN_W = $clog2(MANY_WIN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [SUB_W-1:0]       sub_q;
    logic [WIN_W-1:0]       win_q;
    logic                   last_cycle;
    logic                   last_win;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], lock_raw};
    end
    assign lock_sync = sync_q[SYNC_STAGES-1];

    assign last_cycle = (int'(sub_q) == win_cycles(crit, SHORT_WIN, LONG_WIN) - 1);
    assign last_win   = (int'(win_q) == win_needed(crit, FEW_WIN, MANY_WIN) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run || !lock_sync) begin
            sub_q  <= '0;
            win_q  <= '0;
            locked <= 1'b0;
        end else if (!locked) begin
            if (last_cycle) begin
                sub_q <= '0;
                if (last_win) locked <= 1'b1;
                else          win_q  <= win_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pllc_src_sel.sv
module pllc_src_sel
    import pllc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_src,
    input  logic [1:0] code,
    input  logic       xtal_ok,
    input  logic       rtc_ok,
    input  logic       pll_ready,
    output src_e       src
);
    src_e req, nxt;

    always_comb begin
        req = src;
        if (wr_src) begin
            unique case (src_e'(code))
                SRC_XTAL: if (xtal_ok)   req = SRC_XTAL;
                SRC_RTC:  if (rtc_ok)    req = SRC_RTC;
                SRC_PLL:  if (pll_ready) req = SRC_PLL;
                default:  req = src;
            endcase
        end
        nxt = (req == SRC_PLL && !pll_ready) ? SRC_XTAL : req;
    end

    always_ff @(posedge clk) begin
        if (rst) src <= SRC_XTAL;
        else     src <= nxt;
    end
endmodule

// File: rtl/pllc_irq_ctl.sv
module pllc_irq_ctl
    import pllc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    input  logic          locked,
    output ctl_t          ctl,
    output logic          irq
);
    logic locked_d;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) locked_d <= 1'b0;
        else     locked_d <= locked;
    end

    assign rise = locked && !locked_d;
    assign fall = !locked && locked_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.en      <= wdata[CTL_EN];
                ctl.lock_ie <= wdata[CTL_LOCK_IE];
                ctl.unlk_ie <= wdata[CTL_UNLK_IE];
            end
            ctl.lock_flag <= rise || (ctl.lock_flag && !(wr_ctl && wdata[CTL_LOCK_FL]));
            ctl.unlk_flag <= fall || (ctl.unlk_flag && !(wr_ctl && wdata[CTL_UNLK_FL]));
        end
    end

    assign irq = (ctl.lock_flag && ctl.lock_ie) || (ctl.unlk_flag && ctl.unlk_ie);
endmodule

// File: rtl/pllc_top.sv
module pllc_top
    import pllc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_WIN   = 1,
    parameter int LONG_WIN    = 20,
    parameter int FEW_WIN     = 8,
    parameter int MANY_WIN    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          lock_raw,
    input  logic          xtal_ok,
    input  logic          pll_clk_ok,
    input  logic          rtc_ok,
    output logic [1:0]    clk_sel,
    output logic          pll_en,
    output logic          irq
);
    logic       wr_cfg, wr_ctl;
    logic [1:0] crit_q;
    logic       locked, lock_sync, pll_ready;
    ctl_t       ctl;
    src_e       src;
    logic       unused_wbits;

    assign wr_cfg = bus_wr && !bus_addr;
    assign wr_ctl = bus_wr &&  bus_addr;
    assign unused_wbits = ^bus_wdata[DW-1:CTL_LOCKED];

    always_ff @(posedge clk) begin
        if (rst)                  crit_q <= 2'b00;
        else if (wr_cfg && !ctl.en) crit_q <= bus_wdata[CFG_CRIT_LO +: 2];
    end

    pllc_lock_qual #(
        .SYNC_STAGES(SYNC_STAGES), .SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN),
        .FEW_WIN(FEW_WIN), .MANY_WIN(MANY_WIN)
    ) u_qual (
        .clk(clk), .rst(rst), .run(ctl.en), .crit(crit_q),
        .lock_raw(lock_raw), .lock_sync(lock_sync), .locked(locked)
    );

    assign pll_ready = ctl.en && locked && pll_clk_ok;

    pllc_src_sel u_sel (
        .clk(clk), .rst(rst), .wr_src(wr_cfg), .code(bus_wdata[CFG_SRC_LO +: 2]),
        .xtal_ok(xtal_ok), .rtc_ok(rtc_ok), .pll_ready(pll_ready), .src(src)
    );

    pllc_irq_ctl u_irq (
        .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(bus_wdata),
        .locked(locked), .ctl(ctl), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[CFG_SRC_LO +: 2]  = src;
            bus_rdata[CFG_CRIT_LO +: 2] = crit_q;
        end else begin
            bus_rdata[CTL_EN]      = ctl.en;
            bus_rdata[CTL_LOCK_IE] = ctl.lock_ie;
            bus_rdata[CTL_UNLK_IE] = ctl.unlk_ie;
            bus_rdata[CTL_LOCK_FL] = ctl.lock_flag;
            bus_rdata[CTL_UNLK_FL] = ctl.unlk_flag;
            bus_rdata[CTL_LOCKED]  = locked;
        end
    end

    assign clk_sel = src;
    assign pll_en  = ctl.en;
endmodule

// File: rtl/pllc_chk.sv
module pllc_chk
    import pllc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [1:0] clk_sel,
    input logic       pll_en,
    input logic       pll_clk_ok,
    input logic       locked,
    input logic       lock_sync,
    input logic [1:0] crit,
    input ctl_t       ctl
);
    // R3
    sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        clk_sel != 2'b11);

    // R4
    pll_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel != 2'b01 && !(pll_en && locked && pll_clk_ok)) |=> clk_sel != 2'b01);

    // R5
    pll_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 2'b01 && !(pll_en && locked && pll_clk_ok) && !(bus_wr && !bus_addr))
        |=> clk_sel == 2'b00);

    // R6
    crit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        pll_en |=> $stable(crit));

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_sync |=> !locked);

    // R9
    lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |=> ctl.lock_flag);

    // R9
    unlock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |=> ctl.unlk_flag);
endmodule

bind pllc_top pllc_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .clk_sel(clk_sel), .pll_en(pll_en), .pll_clk_ok(pll_clk_ok),
    .locked(locked), .lock_sync(lock_sync), .crit(crit_q), .ctl(ctl)
);

// File: tb/test_pllc_top.sv
module test_pllc_top;
    localparam int CLK_PERIOD = 20;
    localparam int NVEC = 10;
    // {code[1:0], xtal_ok, rtc_ok, expected source[1:0]}
    localparam logic [5:0] SEL_VEC [NVEC] = '{
        6'b10_1_1_10, 6'b11_1_1_10, 6'b01_1_1_10, 6'b00_0_1_10, 6'b00_1_0_00,
        6'b10_1_0_00, 6'b11_1_1_00, 6'b10_0_1_10, 6'b01_1_1_10, 6'b00_1_1_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       lock_raw = 1'b0;
    logic       xtal_ok = 1'b1;
    logic       pll_clk_ok = 1'b1;
    logic       rtc_ok = 1'b1;
    logic [1:0] clk_sel;
    logic       pll_en;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] rv;

    pllc_top i_pllc_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_raw(lock_raw),
        .xtal_ok(xtal_ok), .pll_clk_ok(pll_clk_ok), .rtc_ok(rtc_ok),
        .clk_sel(clk_sel), .pll_en(pll_en), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 clk_sel", {6'b0, clk_sel}, 8'h00);
        check("R1 pll_en", {7'b0, pll_en}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(1'b0, rv); check("R1 reg0", rv, 8'h00);
        rd(1'b1, rv); check("R1 reg1", rv, 8'h00);

        // source table: R2 valid gating, R3 reserved, R4 PLL while unlocked
        for (int i = 0; i < NVEC; i++) begin
            xtal_ok = SEL_VEC[i][3];
            rtc_ok  = SEL_VEC[i][2];
            wr(1'b0, {6'b0, SEL_VEC[i][5:4]});
            check(SEL_VEC[i][5:4] == 2'b11 ? "R3 table" :
                  SEL_VEC[i][5:4] == 2'b01 ? "R4 table" : "R2 table",
                  {6'b0, clk_sel}, {6'b0, SEL_VEC[i][1:0]});
            rd(1'b0, rv);
            check("R2 field", {6'b0, rv[1:0]}, {6'b0, SEL_VEC[i][1:0]});
        end
        xtal_ok = 1'b1; rtc_ok = 1'b1;

        // R7 criteria 00: 8 windows of 1 cycle
        wr(1'b1, 8'h01);
        @(negedge clk); lock_raw = 1'b1;
        cycles(9);  rd(1'b1, rv); check("R7 early 8x1", {7'b0, rv[5]}, 8'h00);
        cycles(1);  rd(1'b1, rv); check("R7 on time 8x1", {7'b0, rv[5]}, 8'h01);
        cycles(2);  rd(1'b1, rv);
        check("R9 lock flag", {7'b0, rv[3]}, 8'h01);
        check("R10 irq masked", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h03);
        check("R10 irq lock", {7'b0, irq}, 8'h01);

        // R4 PLL needs pll_clk_ok
        pll_clk_ok = 1'b0;
        wr(1'b0, 8'h01);
        check("R4 invalid pll", {6'b0, clk_sel}, 8'h00);
        pll_clk_ok = 1'b1;
        wr(1'b0, 8'h01);
        check("R4 pll accepted", {6'b0, clk_sel}, 8'h01);

        // R6 criteria frozen while enabled
        wr(1'b0, 8'h0D);
        rd(1'b0, rv); check("R6 frozen", rv, 8'h01);

        // R11 clear lock flag
        wr(1'b1, 8'h0B);
        rd(1'b1, rv); check("R11 clear lock", {7'b0, rv[3]}, 8'h00);
        check("R10 irq cleared", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h05);

        // R5 loss of lock while selected
        @(negedge clk); lock_raw = 1'b0;
        cycles(6);
        check("R5 fallback out", {6'b0, clk_sel}, 8'h00);
        rd(1'b0, rv); check("R5 fallback field", {6'b0, rv[1:0]}, 8'h00);
        rd(1'b1, rv);
        check("R9 unlock flag", {7'b0, rv[4]}, 8'h01);
        check("R7 status low", {7'b0, rv[5]}, 8'h00);
        check("R10 irq unlock", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h15);
        rd(1'b1, rv); check("R11 clear unlock", {7'b0, rv[4]}, 8'h00);

        // R8 restart on dropout, criteria 01: 16 windows of 1 cycle
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h04);
        rd(1'b0, rv); check("R6 write when disabled", rv, 8'h04);
        wr(1'b1, 8'h01);
        @(negedge clk); lock_raw = 1'b1;
        cycles(10);
        lock_raw = 1'b0;
        @(negedge clk); lock_raw = 1'b1;
        cycles(17); rd(1'b1, rv); check("R8 restart early", {7'b0, rv[5]}, 8'h00);
        cycles(1);  rd(1'b1, rv); check("R8 restart on time", {7'b0, rv[5]}, 8'h01);

        // R5 disabling the PLL while selected
        wr(1'b0, 8'h05);
        check("R4 pll selected", {6'b0, clk_sel}, 8'h01);
        wr(1'b1, 8'h00);
        cycles(3);
        check("R5 disable fallback", {6'b0, clk_sel}, 8'h00);
        rd(1'b1, rv); check("R9 unlock on disable", {7'b0, rv[4]}, 8'h01);

        // R7 criteria 10: 8 windows of 20 cycles
        lock_raw = 1'b0;
        cycles(3);
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h01);
        @(negedge clk); lock_raw = 1'b1;
        cycles(161); rd(1'b1, rv); check("R7 early 8x20", {7'b0, rv[5]}, 8'h00);
        cycles(1);   rd(1'b1, rv); check("R7 on time 8x20", {7'b0, rv[5]}, 8'h01);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule